// File: doc/BRIEF.md
# DC offset calibration sequencer

This controller brings up the three analog pieces of an offset-trimmed amplifier stage: a correction DAC, the amplifier, and a comparator that looks at the amplifier output. It then finds the DAC code that cancels the stage's DC offset. A start request from the control processor begins the work. The sequencer switches the DAC on first, then the amplifier, then the comparator. Each block gets its own settling time, counted in microsecond ticks, before the next one is switched on. After that it runs an eight-step successive-approximation search, most significant bit first, and reads the comparator after each trial code has settled.

When the search ends, the result is latched as the calibration value and the comparator is switched off. The amplifier and DAC stay running at that code. The calibrated flag then rises, and it serves as the done indication. A later start request while the block is running calibrates again, without switching the amplifier or DAC off. Every enable is gated by the supply-good input. A loss of supply drops all enables at once, abandons any search and returns the block to idle.

Top module: `dco_cal_seq`

## Requirements
- R1: After reset all three enables are low, and `dac_code`, `cal_value` and `calibrated` are zero.
- R2: A start request in idle with `vdd_ok` high raises `en_dac` first. `en_amp` rises only after `en_dac` has been high for T_DAC_US+1 sampled `us_tick` pulses (default 6). `en_cmp` rises only after `en_amp` has been high for T_AMP_US+1 further pulses (default 7).
- R3: After `en_cmp` has been high for T_CMP_US+1 tick pulses, the search begins at trial code 8'h80 and resolves one bit per step, MSB first. Each trial is held for T_SET_US+1 tick pulses, and then `cmp_out` is sampled. A value of 1 means the trial code is too high, so that bit is cleared; a value of 0 keeps it. `en_cmp` therefore stays high for T_CMP_US+1+8*(T_SET_US+1) tick pulses (default 28).
- R4: When the last bit is resolved, `cal_value` and `dac_code` both take the result and `en_cmp` falls while `en_amp` and `en_dac` stay high. With a comparator that reports 1 exactly when `dac_code` exceeds the offset, the result equals the offset, from 0 through 255.
- R5: `calibrated` is high exactly when a search has completed since the last supply loss or reset, `en_amp` and `en_dac` are high, and `en_cmp` is low.
- R6: No enable rises while `vdd_ok` is low, and a start request made while `vdd_ok` is low is ignored.
- R7: While `vdd_ok` is low all enables are low, including the first cycle in which it has fallen. A supply loss during a search abandons it: `calibrated` goes low, `cal_value` keeps its previous value, and the block stays idle until a new start request.
- R8: A start request while calibrated raises `en_cmp` and repeats the settling wait and the search. `en_amp` and `en_dac` stay high throughout.
- R9: Start requests that arrive during power-up or during a search are ignored. The search in progress completes with unchanged timing and result.
- R10: While `calibrated` is high, `dac_code` equals `cal_value` or `cal_value` plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| vdd_ok | input | 1 | Analog supply is good |
| start | input | 1 | Calibration request |
| cmp_out | input | 1 | Comparator result, 1 when the DAC code is above the offset |
| en_amp | output | 1 | Amplifier enable |
| en_dac | output | 1 | Correction DAC enable |
| en_cmp | output | 1 | Comparator enable |
| dac_code | output | 8 | Code driven to the correction DAC |
| calibrated | output | 1 | Calibration complete and amplifier in its calibrated configuration |
| cal_value | output | 8 | Stored result of the last completed search |

## Verification
The hardest case to reach from the ports is a supply collapse in the middle of a search. The enables must drop in that same cycle, and the stored result must survive even though the trial register holds a half-resolved code. The bench lets the search run past several trial bits, then pulls `vdd_ok` low one cycle after a clock edge. It checks the enables and flag straight away, then restores supply and shows that the block stays idle until a fresh request. The same bench also fires extra start pulses during a search and requests recalibration from the running state. Tick counts measured between enable edges catch any restart or any shortened settling window.

// File: rtl/dco_cal_seq.sv
module dco_cal_seq #(
  parameter int DAC_W    = 8,
  parameter int T_DAC_US = 5,
  parameter int T_AMP_US = 6,
  parameter int T_CMP_US = 3,
  parameter int T_SET_US = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             vdd_ok,
  input  logic             start,
  input  logic             cmp_out,
  output logic             en_amp,
  output logic             en_dac,
  output logic             en_cmp,
  output logic [DAC_W-1:0] dac_code,
  output logic             calibrated,
  output logic [DAC_W-1:0] cal_value
);
  localparam int T_A   = (T_DAC_US > T_AMP_US) ? T_DAC_US : T_AMP_US;
  localparam int T_B   = (T_CMP_US > T_SET_US) ? T_CMP_US : T_SET_US;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1) + 1;
  localparam int IDX_W = (DAC_W > 1) ? $clog2(DAC_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PDAC, S_PAMP, S_PCMP, S_SRCH, S_RUN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, lim;
  logic [IDX_W-1:0] idx;
  logic [DAC_W-1:0] trial_q, cal_q;
  logic             amp_q, dacen_q, cmp_q, done_q;

  always_comb begin
    case (st)
      S_PDAC:  lim = CNT_W'(T_DAC_US);
      S_PAMP:  lim = CNT_W'(T_AMP_US);
      S_PCMP:  lim = CNT_W'(T_CMP_US);
      S_SRCH:  lim = CNT_W'(T_SET_US);
      default: lim = '0;
    endcase
  end

  wire             timing   = (st == S_PDAC) || (st == S_PAMP) || (st == S_PCMP) || (st == S_SRCH);
  wire             wait_end = timing && us_tick && (cnt == lim);
  wire [DAC_W-1:0] bit_sel  = DAC_W'(1) << idx;
  wire [DAC_W-1:0] resolved = cmp_out ? (trial_q & ~bit_sel) : trial_q;
  wire [DAC_W-1:0] next_try = resolved | (bit_sel >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      trial_q <= '0;
      cal_q   <= '0;
      amp_q   <= 1'b0;
      dacen_q <= 1'b0;
      cmp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (!vdd_ok) begin
      st      <= S_IDLE;
      cnt     <= '0;
      trial_q <= cal_q;
      amp_q   <= 1'b0;
      dacen_q <= 1'b0;
      cmp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (!timing || wait_end)
        cnt <= '0;
      else if (us_tick)
        cnt <= cnt + 1'b1;

      case (st)
        S_IDLE: if (start) begin
          dacen_q <= 1'b1;
          st      <= S_PDAC;
        end
        S_PDAC: if (wait_end) begin
          amp_q <= 1'b1;
          st    <= S_PAMP;
        end
        S_PAMP: if (wait_end) begin
          cmp_q <= 1'b1;
          st    <= S_PCMP;
        end
        S_PCMP: if (wait_end) begin
          idx     <= IDX_W'(DAC_W - 1);
          trial_q <= DAC_W'(1) << (DAC_W - 1);
          st      <= S_SRCH;
        end
        S_SRCH: if (wait_end) begin
          if (idx == '0) begin
            trial_q <= resolved;
            cal_q   <= resolved;
            cmp_q   <= 1'b0;
            done_q  <= 1'b1;
            st      <= S_RUN;
          end else begin
            trial_q <= next_try;
            idx     <= idx - 1'b1;
          end
        end
        S_RUN: if (start) begin
          cmp_q <= 1'b1;
          st    <= S_PCMP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign en_dac     = dacen_q & vdd_ok;
  assign en_amp     = amp_q & vdd_ok;
  assign en_cmp     = cmp_q & vdd_ok;
  assign dac_code   = trial_q;
  assign cal_value  = cal_q;
  assign calibrated = done_q & en_amp & en_dac & ~en_cmp;
endmodule

module dco_cal_seq_chk #(
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vdd_ok,
  input logic             en_amp,
  input logic             en_dac,
  input logic             en_cmp,
  input logic [DAC_W-1:0] dac_code,
  input logic             calibrated,
  input logic [DAC_W-1:0] cal_value
);
  assert_dac_rise_vdd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_dac) |-> vdd_ok);
  assert_amp_rise_vdd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_amp) |-> vdd_ok);
  assert_cmp_rise_vdd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_cmp) |-> vdd_ok);
  assert_off_without_vdd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_ok |-> !(en_amp || en_dac || en_cmp));
  assert_flag_after_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_ok) |=> !calibrated);
  assert_amp_after_dac_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_amp) |-> en_dac);
  assert_cmp_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_cmp) |-> (en_amp && en_dac));
  assert_result_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en_cmp) && vdd_ok) |-> (en_amp && en_dac && dac_code == cal_value));
  assert_flag_config_R5: assert property (@(posedge clk) disable iff (!rst_n)
    calibrated |-> (en_amp && en_dac && !en_cmp));
  assert_code_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    calibrated |-> (dac_code == cal_value || dac_code == cal_value + 1'b1));
endmodule

bind dco_cal_seq dco_cal_seq_chk #(.DAC_W(DAC_W)) chk_i (.*);

// File: tb/dco_cal_seq_tb_top.sv
module dco_cal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int T_DAC_US = 5, T_AMP_US = 6, T_CMP_US = 3, T_SET_US = 2;
  localparam int CMP_SPAN = T_CMP_US + 1 + 8 * (T_SET_US + 1);

  logic clk = 0, rst_n = 0, us_tick = 0, vdd_ok = 0, start = 0;
  logic [7:0] offset = 8'h00;
  logic en_amp, en_dac, en_cmp, calibrated;
  logic [7:0] dac_code, cal_value;
  wire cmp_out = en_cmp && (dac_code > offset);

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];

  dco_cal_seq #(.DAC_W(8), .T_DAC_US(T_DAC_US), .T_AMP_US(T_AMP_US),
                .T_CMP_US(T_CMP_US), .T_SET_US(T_SET_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .vdd_ok(vdd_ok), .start(start),
    .cmp_out(cmp_out), .en_amp(en_amp), .en_dac(en_dac), .en_cmp(en_cmp),
    .dac_code(dac_code), .calibrated(calibrated), .cal_value(cal_value));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      us_tick = (ph == TICK_DIV - 1);
      ph = (ph + 1) % TICK_DIV;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic p_dac = 0, p_amp = 0, p_cmp = 0, p_cal = 0, fresh = 0;
  int cnt_a = 0, cnt_b = 0, cnt_c = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (en_dac && !p_dac) begin
        check(vdd_ok, "R6 dac enable rose with supply", int'(vdd_ok), 1);
        cnt_a = us_tick ? 1 : 0;
      end else if (en_dac && !en_amp) cnt_a += int'(us_tick);
      if (en_amp && !p_amp) begin
        check(cnt_a == T_DAC_US + 1, "R2 dac settle ticks", cnt_a, T_DAC_US + 1);
        cnt_b = us_tick ? 1 : 0;
        fresh = 1;
      end else if (en_amp && !en_cmp && fresh) cnt_b += int'(us_tick);
      if (en_cmp && !p_cmp) begin
        check(en_amp && en_dac, "R2 comparator enabled last", int'(en_amp && en_dac), 1);
        check(!calibrated, "R5 flag low while comparator on", int'(calibrated), 0);
        if (fresh) check(cnt_b == T_AMP_US + 1, "R2 amp settle ticks", cnt_b, T_AMP_US + 1);
        fresh = 0;
        cnt_c = us_tick ? 1 : 0;
      end else if (en_cmp) cnt_c += int'(us_tick);
      if (!en_cmp && p_cmp && vdd_ok)
        check(cnt_c == CMP_SPAN, "R3 search tick span", cnt_c, CMP_SPAN);
      if (p_amp && !en_amp && vdd_ok)
        check(0, "R8 amplifier dropped during operation", 0, 1);
      if (calibrated && !p_cal) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected completion", int'(cal_value), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cal_value == e, "R4 stored result", int'(cal_value), int'(e));
          check(dac_code == e, "R4 dac at result", int'(dac_code), int'(e));
          check(en_amp && en_dac && !en_cmp, "R5 calibrated config",
                int'({en_amp, en_dac, en_cmp}), 6);
        end
      end
    end
    p_dac = en_dac; p_amp = en_amp; p_cmp = en_cmp; p_cal = calibrated;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic wait_cal();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (calibrated) break;
    end
    check(calibrated, "R4 calibration finished", int'(calibrated), 1);
  endtask

  task automatic run_cal(input logic [7:0] off);
    offset = off;
    exp_q.push_back(off);
    pulse_start();
    wait_cal();
    repeat (3) @(negedge clk);
    check(dac_code == cal_value, "R10 code holds result", int'(dac_code), int'(cal_value));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!en_amp && !en_dac && !en_cmp, "R1 enables low", int'({en_amp, en_dac, en_cmp}), 0);
    check(dac_code == 0 && cal_value == 0, "R1 codes zero", int'(dac_code), 0);
    check(!calibrated, "R1 flag low", int'(calibrated), 0);

    pulse_start();
    repeat (20) @(negedge clk);
    check(!en_amp && !en_dac && !en_cmp, "R6 start without supply ignored",
          int'({en_amp, en_dac, en_cmp}), 0);

    @(posedge clk); #1 vdd_ok = 1;
    run_cal(8'h5A);
    run_cal(8'h00);
    run_cal(8'hFF);
    run_cal(8'h80);
    run_cal(8'h7F);

    offset = 8'h33;
    exp_q.push_back(8'h33);
    pulse_start();
    for (int i = 0; i < 500 && !en_cmp; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (7) @(negedge clk);
    pulse_start();
    wait_cal();
    check(cal_value == 8'h33, "R9 restart ignored", int'(cal_value), 8'h33);

    offset = 8'h10;
    pulse_start();
    for (int i = 0; i < 500 && !en_cmp; i++) @(negedge clk);
    repeat (35) @(negedge clk);
    @(posedge clk); #1 vdd_ok = 0;
    @(negedge clk);
    check(!en_amp && !en_dac && !en_cmp, "R7 enables drop with supply",
          int'({en_amp, en_dac, en_cmp}), 0);
    @(negedge clk);
    check(!calibrated, "R7 flag cleared", int'(calibrated), 0);
    check(cal_value == 8'h33, "R7 stored value kept", int'(cal_value), 8'h33);
    repeat (5) @(negedge clk);
    @(posedge clk); #1 vdd_ok = 1;
    repeat (40) @(negedge clk);
    check(!en_amp && !en_dac && !en_cmp, "R7 idle after supply returns",
          int'({en_amp, en_dac, en_cmp}), 0);

    run_cal(8'hC3);
    run_cal(8'h01);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected results seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule